// File: doc/BRIEF.md
# Stereo Zero-Cross Detector

This block watches the audio words of a two-channel stream as they leave a serializer. Each word comes with a valid strobe and a tag that says whether it belongs to the left or the right channel. For each channel that has detection switched on, the block remembers the sign of that channel's last word. It raises a sticky flag for the channel when the sign flips, or when a word is zero across its whole active width.

The word width is chosen at run time by a two-bit code. The sign bit and the zero test follow that width, and any bits above the active width play no part. Software clears a flag by pulsing a write-one strobe, or by turning that channel's detection off. Each flag is gated by its own interrupt enable, and the gated flags are merged into one interrupt output.

The serializer, the FIFOs and the register front end sit outside this block.

Top module: `stereo_zc_detect`

## Requirements
- R1: After reset, `zc_flag_l`, `zc_flag_r` and `zc_irq` are 0.
- R2: For a sample on an enabled channel whose detector is armed, a sign bit that differs from that channel's previous recorded sign sets the channel's flag on the next clock edge.
- R3: A sample whose bits are all zero within the active width sets its channel's flag on the next edge, whatever the bits above the active width hold.
- R4: The sign bit is bit 7, 15, 23 or 31 for width codes 0, 1, 2 or 3. The zero test covers bits 0 up to that sign bit.
- R5: After reset, and after each disable-to-enable transition, the first sample of a channel only records its sign and arms the detector. That sample sets the flag only if R3 applies to it.
- R6: A flag stays set until a write-one strobe (`zc_clr_l`/`zc_clr_r` high for one cycle) clears it on the next edge.
- R7: While a channel's detect enable is 0, its flag is 0 one edge later and stays 0. Samples for that channel are ignored and disarm its detector.
- R8: When a set event and a clear strobe for the same channel fall in the same cycle, the flag ends up set.
- R9: A sample tagged left (`smp_right`=0) never changes right-channel state, and a sample tagged right (`smp_right`=1) never changes left-channel state.
- R10: `zc_irq` is 1 exactly when (`zc_flag_l` and `irq_en_l`) or (`zc_flag_r` and `irq_en_r`) holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | A sample is presented this cycle |
| smp_right | input | 1 | Channel tag: 0 left, 1 right |
| smp_data | input | DATA_W | Sample word, LSB-aligned |
| width_code | input | 2 | Active width: 0=8, 1=16, 2=24, 3=32 bits |
| det_en_l | input | 1 | Left detect enable |
| det_en_r | input | 1 | Right detect enable |
| zc_clr_l | input | 1 | Left flag write-one-to-clear strobe |
| zc_clr_r | input | 1 | Right flag write-one-to-clear strobe |
| irq_en_l | input | 1 | Left interrupt enable |
| irq_en_r | input | 1 | Right interrupt enable |
| zc_flag_l | output | 1 | Left zero-cross flag |
| zc_flag_r | output | 1 | Right zero-cross flag |
| zc_irq | output | 1 | Masked merged interrupt |

## Verification
Two functions of a channel can act in the same cycle: a flag-setting sample and the software clear strobe. The bench provokes this by pulsing the clear in the very cycle a sign-flipping sample arrives, and again with a zero sample. It then expects the flag to read 1 after the edge and to drop only after a later, lone clear. The same collision is also judged while the enable is falling, where the disable must win, and it appears repeatedly in a long stretch of random stimulus that is compared cycle by cycle against a model built from the requirements.

// File: rtl/zcd_pkg.sv
`timescale 1ns/1ps
// Package: shared types and constants of the stereo zero-cross detector.
// Assumes samples are made of 8-bit lanes, with the active width given as a lane count minus one.
package zcd_pkg;
    localparam int unsigned LANE_W = 8;
    localparam int unsigned NUM_CH = 2;

    typedef enum logic [1:0] {
        WC_8  = 2'd0,
        WC_16 = 2'd1,
        WC_24 = 2'd2,
        WC_32 = 2'd3
    } wcode_e;

    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;
endpackage

// File: rtl/zcd_sample_eval.sv
`timescale 1ns/1ps
// Module: zcd_sample_eval
// Purely combinational. Takes one sample word and extracts the sign bit at the active width,
// plus an all-zero indication that covers only the active lanes.
// Assumes DATA_W is a whole number of lanes and at most four lanes, so a 2-bit code can reach them all.
module zcd_sample_eval
    import zcd_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] data,
    input  wcode_e            wcode,
    output logic              sign,
    output logic              is_zero
);
    localparam int unsigned LANES = DATA_W / LANE_W;

    logic [LANES-1:0] lane_nz;
    logic [LANES-1:0] lane_act;
    logic [LANES-1:0] lane_msb;

    // Per-lane facts: is the lane non-zero, is it inside the active width, and its top bit.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_nz[i]  = |data[i*LANE_W +: LANE_W];
        assign lane_act[i] = (i <= int'(wcode));
        assign lane_msb[i] = data[i*LANE_W + LANE_W - 1];
    end

    // Zero test over the active lanes only; the sign comes from the top active lane.
    always_comb begin
        is_zero = ~|(lane_nz & lane_act);
        sign    = lane_msb[wcode];
    end

    initial begin
        assert (DATA_W % LANE_W == 0 && LANES >= 1 && LANES <= 4)
            else $error("zcd_sample_eval: DATA_W must be 8, 16, 24 or 32");
    end
endmodule

// File: rtl/zcd_channel.sv
`timescale 1ns/1ps
// Module: zcd_channel
// Tracks one channel: the previously recorded sign, an armed bit and the sticky flag.
// Assumes 'hit' is high only for a valid sample that carries this channel's tag.
// A set event beats a simultaneous clear. A low enable clears the flag and disarms the detector.
module zcd_channel (
    input  logic clk,
    input  logic rst_n,
    input  logic det_en,
    input  logic hit,
    input  logic sign,
    input  logic is_zero,
    input  logic clr,
    output logic flag
);
    logic prev_sign;
    logic armed;
    logic set_evt;

    // A crossing is a zero sample, or a sign flip once the detector is armed.
    always_comb begin
        set_evt = det_en && hit && (is_zero || (armed && (sign != prev_sign)));
    end

    // Sign history and arming: record only while enabled, disarm while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_sign <= 1'b0;
            armed     <= 1'b0;
        end else if (!det_en) begin
            armed     <= 1'b0;
        end else if (hit) begin
            prev_sign <= sign;
            armed     <= 1'b1;
        end
    end

    // Sticky flag: set wins over clear, and disable forces it low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (!det_en) begin
            flag <= 1'b0;
        end else if (set_evt) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

    // R7: a disabled channel shows no flag after the edge.
    a_r7_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !det_en |=> !flag);
    // R8: a crossing leaves the flag set even under a clear strobe.
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> flag);
    // R6: the flag holds without a clear.
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && det_en && !clr) |=> flag);
    // R6: a lone clear drops the flag.
    a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (det_en && clr && !set_evt) |=> !flag);
endmodule

// File: rtl/stereo_zc_detect.sv
`timescale 1ns/1ps
// Module: stereo_zc_detect (top)
// Stereo zero-cross detector. One shared evaluator decodes the sample presented this cycle,
// and one tracker per channel keeps that channel's state. The interrupt is the OR of the flags,
// each gated by its own enable.
// Assumes at most one sample per cycle, with smp_right choosing the channel.
module stereo_zc_detect
    import zcd_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic              smp_right,
    input  logic [DATA_W-1:0] smp_data,
    input  logic [1:0]        width_code,
    input  logic              det_en_l,
    input  logic              det_en_r,
    input  logic              zc_clr_l,
    input  logic              zc_clr_r,
    input  logic              irq_en_l,
    input  logic              irq_en_r,
    output logic              zc_flag_l,
    output logic              zc_flag_r,
    output logic              zc_irq
);
    logic              s_sign;
    logic              s_zero;
    logic [NUM_CH-1:0] en_v;
    logic [NUM_CH-1:0] clr_v;
    logic [NUM_CH-1:0] ien_v;
    logic [NUM_CH-1:0] hit_v;
    logic [NUM_CH-1:0] flag_v;

    zcd_sample_eval #(.DATA_W(DATA_W)) u_eval (
        .data    (smp_data),
        .wcode   (wcode_e'(width_code)),
        .sign    (s_sign),
        .is_zero (s_zero)
    );

    // Gather the per-channel controls into vectors indexed by channel.
    always_comb begin
        en_v  = {det_en_r, det_en_l};
        clr_v = {zc_clr_r, zc_clr_l};
        ien_v = {irq_en_r, irq_en_l};
    end

    // One tracker per channel; a sample reaches only the channel named by its tag.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign hit_v[c] = smp_valid && (smp_right == c[0]);
        zcd_channel u_trk (
            .clk     (clk),
            .rst_n   (rst_n),
            .det_en  (en_v[c]),
            .hit     (hit_v[c]),
            .sign    (s_sign),
            .is_zero (s_zero),
            .clr     (clr_v[c]),
            .flag    (flag_v[c])
        );
    end

    // Outputs: the flags and the masked interrupt merge.
    always_comb begin
        zc_flag_l = flag_v[CH_LEFT];
        zc_flag_r = flag_v[CH_RIGHT];
        zc_irq    = |(flag_v & ien_v);
    end

    // R1: flags are low on the first cycle out of reset.
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!zc_flag_l && !zc_flag_r));
    // R10: no interrupt while both enables are off.
    a_r10_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_en_l && !irq_en_r) |-> !zc_irq);
    // R9: a left-tagged sample leaves the right flag unchanged unless right controls act.
    a_r9_right_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !smp_right && det_en_r && !zc_clr_r) |=> $stable(zc_flag_r));
endmodule

// File: tb/sim_stereo_zc_detect.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver computes the expected outputs from a requirement-level model and
// queues them. The monitor pops one entry after every rising edge and compares it with the outputs.
module sim_stereo_zc_detect;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 0, smp_right = 0;
    logic [31:0] smp_data = '0;
    logic [1:0]  width_code = 2'd3;
    logic        det_en_l = 0, det_en_r = 0, zc_clr_l = 0, zc_clr_r = 0;
    logic        irq_en_l = 0, irq_en_r = 0;
    logic        zc_flag_l, zc_flag_r, zc_irq;

    int n_run = 0, n_fail = 0;
    bit finished = 0;

    typedef struct { logic fl; logic fr; logic irq; string req; } exp_t;
    exp_t q[$];

    // Model state
    logic m_prev[2], m_arm[2], m_flag[2];

    always #2.5 clk = ~clk;

    stereo_zc_detect u0 (.*);

    // Advance the model by one edge using the current inputs, queue the expectation, then wait for the edge.
    task automatic tick(string req);
        exp_t e;
        logic [63:0] mask;
        logic sgn, zr, en, hit, setv, clr;
        mask = (64'd1 << (8 * (width_code + 1))) - 64'd1;
        zr   = (({32'd0, smp_data} & mask) == 64'd0);
        sgn  = smp_data[8 * width_code + 7];
        for (int c = 0; c < 2; c++) begin
            en  = c ? det_en_r : det_en_l;
            clr = c ? zc_clr_r : zc_clr_l;
            hit = smp_valid && (smp_right == c[0]);
            if (!en) begin
                m_flag[c] = 0; m_arm[c] = 0;
            end else begin
                setv = hit && (zr || (m_arm[c] && sgn != m_prev[c]));
                if (hit) begin m_prev[c] = sgn; m_arm[c] = 1; end
                m_flag[c] = setv | (m_flag[c] & ~clr);
            end
        end
        e.fl = m_flag[0]; e.fr = m_flag[1];
        e.irq = (m_flag[0] & irq_en_l) | (m_flag[1] & irq_en_r);
        e.req = req;
        q.push_back(e);
        @(negedge clk);
        smp_valid = 0; zc_clr_l = 0; zc_clr_r = 0;
    endtask

    task automatic sample(logic right, logic [31:0] d, string req);
        smp_valid = 1; smp_right = right; smp_data = d;
        tick(req);
    endtask

    // Monitor: compare after each rising edge, away from the edge itself.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_run++;
                if ({zc_flag_l, zc_flag_r, zc_irq} !== {e.fl, e.fr, e.irq}) begin
                    n_fail++;
                    $display("FAIL %s: flag_l,flag_r,irq got %b%b%b expected %b%b%b",
                             e.req, zc_flag_l, zc_flag_r, zc_irq, e.fl, e.fr, e.irq);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #1000000;
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 2; c++) begin m_prev[c] = 0; m_arm[c] = 0; m_flag[c] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        #0;
        // R1 reset state
        n_run++;
        if ({zc_flag_l, zc_flag_r, zc_irq} !== 3'b000) begin
            n_fail++;
            $display("FAIL R1: got %b%b%b expected 000", zc_flag_l, zc_flag_r, zc_irq);
        end
        det_en_l = 1; det_en_r = 1; irq_en_l = 1; irq_en_r = 1; width_code = 2'd3;
        tick("R1");
        sample(0, 32'h0000_0001, "R5");          // first left sample: record only
        sample(0, 32'h8000_0000, "R2");          // sign flip sets left (R9: right stays)
        tick("R6");                              // sticky
        sample(1, 32'h0000_0005, "R9");          // right first sample, left untouched
        zc_clr_l = 1; tick("R6");                // clear left
        zc_clr_l = 1; sample(0, 32'h0000_0002, "R8"); // flip back to positive with clear
        tick("R8");
        zc_clr_l = 1; tick("R6");
        sample(1, 32'h0000_0000, "R3");          // zero sets right
        irq_en_r = 0; tick("R10");               // masked
        irq_en_r = 1; zc_clr_r = 1; sample(1, 32'h0, "R8"); // zero with clear: set wins
        zc_clr_r = 1; tick("R6");
        // R4 and R3 per width code
        for (int w = 0; w < 4; w++) begin
            width_code = w[1:0];
            zc_clr_l = 1; sample(0, 32'h0000_0001, "R4");
            sample(0, 32'h0000_0001 | (32'h1 << (8 * w + 7)), "R4");
            zc_clr_l = 1; tick("R4");
            if (w < 3) begin
                sample(0, 32'h0000_0001, "R4");
                sample(0, 32'h0000_0001 | (32'h1 << (8 * w + 15)), "R4"); // above width: no flip
                sample(0, 32'hFFFF_FF00 << (8 * w), "R3"); // zero in active width
                zc_clr_l = 1; tick("R3");
            end
        end
        width_code = 2'd3;
        // R7 disable
        sample(0, 32'h0, "R3");
        det_en_l = 0; tick("R7");
        sample(0, 32'h8000_0000, "R7");          // ignored while disabled
        det_en_l = 1; sample(0, 32'h0000_0003, "R5"); // first after re-enable
        sample(0, 32'h0000_0004, "R5");
        det_en_r = 0; zc_clr_r = 1; sample(1, 32'h0, "R7");
        det_en_r = 1; tick("R7");
        // Random stretch
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            smp_valid  = r[0];
            smp_right  = r[1];
            width_code = r[3:2];
            det_en_l   = (r[7:4] != 0);
            det_en_r   = (r[11:8] != 0);
            zc_clr_l   = (r[14:12] == 0);
            zc_clr_r   = (r[17:15] == 0);
            irq_en_l   = r[18];
            irq_en_r   = r[19];
            smp_data   = (r[22:20] == 0) ? 32'h0 : $urandom;
            tick("R2");
        end
        @(negedge clk);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule